// File: doc/BRIEF.md
# Serial Control Register Slave

This block sits on a three-wire control bus (an active-high enable, a serial clock and one data line shared by host and slave) and holds the control settings for an analog receive front end. Two settings are kept. The first is a control byte carrying a power field and a transimpedance range field. The second is an 8-bit fine-gain code that spans about ten decibels in 256 steps. The register values leave the block on dedicated outputs, along with a sleep flag decoded from the power field.

Every frame is sixteen serial clocks long. The first bit picks the direction, seven address bits follow, and then eight data bits; each field goes most significant bit first. A two-bit strap input moves the register bank into one of three address windows. The slave answers only inside the selected window, and it drives the shared line only during the data phase of a read that falls in that window. The bus pins are oversampled by the system clock through a synchronizer, so the serial clock must stay well below the system clock.

Top module: `sctl_slave`

## Requirements
- R1: After reset the power and range fields are 00, the fine gain is 00h, the sleep output is 1 and the data line is released (`sdio_oe` = 0).
- R2: A frame is sampled on rising serial clock edges as {mode, address[6:0], data[7:0]}, each field MSB first, with mode 0 meaning write. A write to window offset 1 loads the fine-gain code.
- R3: A write to window offset 0 loads bits 7:6 into the power field and bits 5:4 into the range field. The sleep output is 0 only when the power field is 11.
- R4: The strap selects the window: 00 gives 00h–0Fh, 01 gives 10h–1Fh, and 10 or 11 gives 70h–7Fh. Writes outside the selected window change nothing.
- R5: A read (mode 1) in the window drives data bits 7..0 for serial clocks 9..16. Each bit is launched after a falling edge, so it is valid at the next rising edge. Offset 0 reads {power, range, 0000} and offset 1 reads the fine gain.
- R6: Offsets 2h–Fh, including the test offset Eh, read as 00h. Writes to them leave the power, range and gain fields unchanged.
- R7: A read addressed outside the selected window leaves `sdio_oe` low for the whole frame.
- R8: If enable drops before the sixteenth rising edge, the frame is discarded and the next frame decodes from its first bit.
- R9: `sdio_oe` is never high during a write or during the first eight clocks of a read, and it falls once enable is low.
- R10: A rising serial clock edge that is seen in the same cycle as enable falling is not counted. A write whose sixteenth edge coincides with the enable drop is discarded.
- R11: Clock edges after the sixteenth in one frame are ignored. The write is committed once, with the data from the first sixteen bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sen | input | 1 | Frame enable, active high |
| sck | input | 1 | Serial clock from host |
| sdio_i | input | 1 | Data line as received |
| strap | input | 2 | Address window select |
| sdio_o | output | 1 | Read data driven onto the line |
| sdio_oe | output | 1 | Output enable for the data line |
| power_o | output | 2 | Power field |
| range_o | output | 2 | Transimpedance range field |
| gain_o | output | 8 | Fine-gain code |
| sleep_o | output | 1 | High unless the power field is 11 |

## Verification
Two events can land in the same system cycle: the final rising serial clock edge of a write, which commits the frame, and the falling enable that ends the frame. The bench provokes this by lowering enable at the same instant as the sixteenth rising edge. The two signals then pass through identical synchronizers and reach the edge logic together, and the check requires that the fine gain keeps its old value. A related pair of checks drops enable early and also sends seventeen clocks, then confirms by readback that only a full, single sixteen-bit write is committed.

// File: rtl/sctl_slave.sv
module sctl_slave #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sen,
  input  logic       sck,
  input  logic       sdio_i,
  input  logic [1:0] strap,
  output logic       sdio_o,
  output logic       sdio_oe,
  output logic [1:0] power_o,
  output logic [1:0] range_o,
  output logic [7:0] gain_o,
  output logic       sleep_o
);

  localparam int CW = 5;
  localparam logic [CW-1:0] LAST = CW'(16);

  logic [SYNC-1:0] sen_sr, sck_sr, dat_sr;
  logic            sck_d;
  logic            sen_s, sck_s, dat_s, rise, fall;
  logic [CW-1:0]   bit_cnt;
  logic [14:0]     sh;
  logic [2:0]      win_hi;
  logic [6:0]      addr_w, addr_r;
  logic [7:0]      wdata, rdata, tx;
  logic            wr_done, arm, drv;
  logic [1:0]      power_q, range_q;
  logic [7:0]      gain_q;

  assign sen_s = sen_sr[SYNC-1];
  assign sck_s = sck_sr[SYNC-1];
  assign dat_s = dat_sr[SYNC-1];
  assign rise  = sen_s & sck_s & ~sck_d;
  assign fall  = sen_s & ~sck_s & sck_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sen_sr <= '0;
      sck_sr <= '0;
      dat_sr <= '0;
      sck_d  <= 1'b0;
    end else begin
      sen_sr <= {sen_sr[SYNC-2:0], sen};
      sck_sr <= {sck_sr[SYNC-2:0], sck};
      dat_sr <= {dat_sr[SYNC-2:0], sdio_i};
      sck_d  <= sck_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
    end else if (!sen_s) begin
      bit_cnt <= '0;
    end else if (rise && bit_cnt != LAST) begin
      bit_cnt <= bit_cnt + 1'b1;
      sh      <= {sh[13:0], dat_s};
    end

  always_comb
    case (strap)
      2'b00:   win_hi = 3'h0;
      2'b01:   win_hi = 3'h1;
      default: win_hi = 3'h7;
    endcase

  assign addr_w  = sh[13:7];
  assign wdata   = {sh[6:0], dat_s};
  assign addr_r  = {sh[5:0], dat_s};
  assign wr_done = rise && bit_cnt == LAST - 1'b1 && !sh[14] && addr_w[6:4] == win_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      power_q <= 2'b00;
      range_q <= 2'b00;
      gain_q  <= 8'h00;
    end else if (wr_done) begin
      case (addr_w[3:0])
        4'h0: {power_q, range_q} <= wdata[7:4];
        4'h1: gain_q <= wdata;
        default: ;
      endcase
    end

  always_comb
    case (addr_r[3:0])
      4'h0:    rdata = {power_q, range_q, 4'h0};
      4'h1:    rdata = gain_q;
      default: rdata = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arm    <= 1'b0;
      drv    <= 1'b0;
      tx     <= '0;
      sdio_o <= 1'b0;
    end else if (!sen_s) begin
      arm <= 1'b0;
      drv <= 1'b0;
    end else begin
      if (rise && bit_cnt == CW'(7) && sh[6] && addr_r[6:4] == win_hi) begin
        arm <= 1'b1;
        tx  <= rdata;
      end
      if (fall && arm) begin
        drv    <= 1'b1;
        sdio_o <= tx[7];
        tx     <= {tx[6:0], 1'b0};
      end
    end

  assign sdio_oe = drv & sen_s;
  assign power_o = power_q;
  assign range_o = range_q;
  assign gain_o  = gain_q;
  assign sleep_o = power_q != 2'b11;

  p_cnt_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST);
  p_abort_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_s |=> bit_cnt == '0);
  p_gain_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_q) |-> $past(bit_cnt) == LAST - 1'b1 && $past(sen_s));
  p_ctrl_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({power_q, range_q}) |-> $past(bit_cnt) == LAST - 1'b1 && $past(sen_s));
  p_oe_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(fall));
  p_oe_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> bit_cnt >= CW'(8));

endmodule

// File: tb/sctl_slave_tb.sv
module sctl_slave_tb_top;
  localparam int HP = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sen = 1'b0, sck = 1'b0, sdio_in = 1'b0;
  logic [1:0] strap = 2'b00;
  logic       sdo, oe, sleep;
  logic [1:0] pwr, rng;
  logic [7:0] gain;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sctl_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sen(sen), .sck(sck), .sdio_i(sdio_in), .strap(strap),
    .sdio_o(sdo), .sdio_oe(oe), .power_o(pwr), .range_o(rng), .gain_o(gain), .sleep_o(sleep)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic rd, input logic [6:0] a, input logic [7:0] d, input int nclk,
                      input logic coinc, output logic [7:0] q, output logic oe_any, output logic oe_early);
    logic [15:0] w;
    w = {rd, a, d}; q = '0; oe_any = 0; oe_early = 0;
    @(negedge clk) sen = 1'b1;
    idle(HP);
    for (int i = 0; i < nclk; i++) begin
      sdio_in = (i < 16 && !(rd && i >= 8)) ? w[15-i] : 1'b0;
      idle(HP);
      if (oe) begin oe_any = 1; if (i < 8) oe_early = 1; end
      if (i >= 8 && i < 16) q = {q[6:0], oe ? sdo : 1'b0};
      sck = 1'b1;
      if (coinc && i == nclk - 1) sen = 1'b0;
      idle(HP);
      if (oe && i < 8) oe_early = 1;
      sck = 1'b0;
    end
    idle(HP);
    sen = 1'b0;
    idle(12);
    chk("R9 released after enable low", oe, 0);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input int nclk = 16, input logic coinc = 0);
    logic [7:0] q; logic any, early;
    xfer(1'b0, a, d, nclk, coinc, q, any, early);
    chk("R9 no drive on write", any, 0);
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] q, output logic any);
    logic early;
    xfer(1'b1, a, 8'h00, 16, 1'b0, q, any, early);
    chk("R9 no drive in address phase", early, 0);
  endtask

  task automatic t_reset;
    chk("R1 power", pwr, 0);
    chk("R1 range", rng, 0);
    chk("R1 gain", gain, 0);
    chk("R1 sleep", sleep, 1);
    chk("R1 oe", oe, 0);
  endtask

  task automatic t_gain;
    logic [7:0] q; logic any;
    strap = 2'b00;
    wr(7'h01, 8'hA5);
    chk("R2 gain write", gain, 8'hA5);
    rd(7'h01, q, any);
    chk("R5 gain drive", any, 1);
    chk("R5 gain readback", q, 8'hA5);
  endtask

  task automatic t_ctrl;
    logic [7:0] q; logic any;
    wr(7'h00, 8'b1110_0110);
    chk("R3 power", pwr, 2'b11);
    chk("R3 range", rng, 2'b10);
    chk("R3 awake", sleep, 0);
    rd(7'h00, q, any);
    chk("R5 ctrl readback", q, 8'hE0);
    for (int p = 0; p < 3; p++) begin
      wr(7'h00, {p[1:0], 2'b01, 4'hF});
      chk("R3 sleep code", sleep, 1);
      chk("R3 range low-gain", rng, 2'b01);
    end
  endtask

  task automatic t_window;
    logic [7:0] q; logic any;
    strap = 2'b01;
    wr(7'h01, 8'h11);
    chk("R4 low window ignored under strap 01", gain, 8'hA5);
    wr(7'h11, 8'h3C);
    chk("R4 window 10h", gain, 8'h3C);
    strap = 2'b10;
    wr(7'h11, 8'h99);
    chk("R4 window 10h ignored under strap 10", gain, 8'h3C);
    wr(7'h71, 8'h5A);
    chk("R4 window 70h", gain, 8'h5A);
    strap = 2'b11;
    rd(7'h71, q, any);
    chk("R4 strap 11 readback", q, 8'h5A);
  endtask

  task automatic t_outside;
    logic [7:0] q; logic any;
    strap = 2'b00;
    rd(7'h11, q, any);
    chk("R7 read 11h floats", any, 0);
    rd(7'h71, q, any);
    chk("R7 read 71h floats", any, 0);
  endtask

  task automatic t_unused;
    logic [7:0] q; logic any;
    logic [1:0] p0, r0;
    strap = 2'b00;
    p0 = pwr; r0 = rng;
    wr(7'h05, 8'hFF);
    wr(7'h0E, 8'hFF);
    wr(7'h0F, 8'hFF);
    chk("R6 gain untouched", gain, 8'h5A);
    chk("R6 ctrl untouched", {p0, r0}, {pwr, rng});
    rd(7'h0E, q, any);
    chk("R6 test offset drives", any, 1);
    chk("R6 test offset zero", q, 0);
    rd(7'h05, q, any);
    chk("R6 offset 5 zero", q, 0);
    rd(7'h0F, q, any);
    chk("R6 offset F zero", q, 0);
  endtask

  task automatic t_abort;
    wr(7'h01, 8'h77, 12);
    chk("R8 aborted write discarded", gain, 8'h5A);
    wr(7'h01, 8'h2B);
    chk("R8 next frame decodes", gain, 8'h2B);
  endtask

  task automatic t_coinc;
    wr(7'h01, 8'hC3, 16, 1'b1);
    chk("R10 coincident last edge discarded", gain, 8'h2B);
  endtask

  task automatic t_extra;
    logic [7:0] q; logic any;
    wr(7'h01, 8'h81, 17);
    chk("R11 extra clock ignored", gain, 8'h81);
    rd(7'h01, q, any);
    chk("R11 readback", q, 8'h81);
  endtask

  initial begin
    idle(5);
    t_reset();
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_gain();
    t_ctrl();
    t_window();
    t_outside();
    t_unused();
    t_abort();
    t_coinc();
    t_extra();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule